// File: doc/BRIEF.md
# Store-Wait Load Predictor

This block remembers which loads have previously read memory ahead of an older store to the same address and been caught doing so. It holds a direct-mapped array of one-bit flags, selected by a slice of the load's instruction address. When the ordering-violation logic reports a violating load, that load's flag is raised. Each load fetched afterwards looks up its flag, and the flag goes with the load toward the scheduler.

A small issue gate is part of the block. It accepts a candidate load together with its flag and a count of the older stores still outstanding. It grants an unflagged load at once. It holds a flagged load until that count reaches zero.

A free-running timer wipes the whole array at a fixed interval, so that stale predictions expire. A violation reported on the same cycle as a wipe still leaves its own entry set.

Top module: `store_wait_predictor`

## Requirements
- R1: While reset is high, and after it falls, every flag reads 0 and `lookup_valid` is low until the first fetch.
- R2: The flag index is `pc[11:2]` (IDX_LSB = 2, IDX_W = 10). Two addresses that differ only in bits [1:0] or in bits above 11 select the same flag. Addresses that differ in bits [11:2] select different flags.
- R3: A violation report raises the flag of `viol_pc`. A fetch of that address on any later cycle, and before the next wipe, returns `lookup_wait` = 1.
- R4: Each fetch request gives exactly one result. `lookup_valid` is high in the cycle after the request is sampled and low in every cycle that follows no request.
- R5: When a fetch and a violation with the same index are sampled on the same edge, the fetch returns the flag's old value and the next fetch returns 1.
- R6: Every CLEAR_PERIOD cycles the whole array is wiped. The first wipe comes on the CLEAR_PERIOD-th rising edge after reset is released. A fetch sampled on the wipe edge still returns the flag as it was before the wipe.
- R7: A violation sampled on the same edge as a wipe leaves its own flag set, and every other flag is cleared.
- R8: A valid candidate load with `iss_wait` = 0 gets `iss_grant` = 1 whatever the older-store count is, and `iss_hold` = 0.
- R9: A valid candidate with `iss_wait` = 1 gets `iss_hold` = 1 and `iss_grant` = 0 while `older_stores` is nonzero, and gets `iss_grant` = 1 once it is zero. With `iss_valid` = 0 both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A load is being fetched this cycle |
| fetch_pc | input | PC_W | Instruction address of the fetched load |
| viol_valid | input | 1 | A load has been reported as violating memory order |
| viol_pc | input | PC_W | Instruction address of the violating load |
| lookup_valid | output | 1 | Registered result of a fetch lookup is present |
| lookup_wait | output | 1 | Predicted store-wait flag for that fetch |
| iss_valid | input | 1 | A candidate load is presented to the issue gate |
| iss_wait | input | 1 | Store-wait flag carried by the candidate |
| older_stores | input | OLD_W | Number of older stores still outstanding |
| iss_grant | output | 1 | Candidate may issue this cycle |
| iss_hold | output | 1 | Candidate is held for older stores |

## Verification
A lookup result is due one edge after its fetch. The driver records the expected flag in a queue on the edge where the fetch is sampled. It takes that value from a bench model that applies wipes and sets in the order the requirements give. The monitor pops the entry at the next falling edge, where `lookup_valid` must be high. The issue-gate outputs are combinational and are checked in the same cycle their inputs are driven, shortly after the falling edge. Wipe timing is tracked by a bench cycle counter that starts at reset release, so the wipe-edge cases can be driven on exactly the right edge.

// File: rtl/swp_pkg.sv
package swp_pkg;

    localparam int DEF_PC_W         = 32;
    localparam int DEF_IDX_W        = 10;
    localparam int DEF_IDX_LSB      = 2;
    localparam int DEF_CLEAR_PERIOD = 16384;
    localparam int DEF_OLD_W        = 6;

    // Registered lookup result travelling with a fetched load
    typedef struct packed {
        logic valid;
        logic wait_bit;
    } pred_t;

    // Issue gate decision for one candidate load
    typedef enum logic [1:0] {
        GATE_IDLE = 2'd0,
        GATE_PASS = 2'd1,
        GATE_HOLD = 2'd2
    } gate_e;

    function automatic gate_e gate_decide(input logic valid,
                                          input logic flagged,
                                          input logic stores_clear);
        if (!valid)
            return GATE_IDLE;
        else if (flagged && !stores_clear)
            return GATE_HOLD;
        else
            return GATE_PASS;
    endfunction

endpackage

// File: rtl/swp_clear_timer.sv
module swp_clear_timer #(
    parameter int CLEAR_PERIOD = swp_pkg::DEF_CLEAR_PERIOD
) (
    input  logic clk,
    input  logic rst,
    output logic clr_o
);
    localparam int CNT_W = (CLEAR_PERIOD > 2) ? $clog2(CLEAR_PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLEAR_PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign clr_o = (cnt_q == LAST);

    // R6
    clear_gap_chk: assert property (@(posedge clk) disable iff (rst)
        clr_o |=> !clr_o);

endmodule

// File: rtl/swp_table.sv
module swp_table #(
    parameter int IDX_W = swp_pkg::DEF_IDX_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr_i,
    input  logic                set_v_i,
    input  logic [IDX_W-1:0]    set_idx_i,
    input  logic                rd_v_i,
    input  logic [IDX_W-1:0]    rd_idx_i,
    output swp_pkg::pred_t      rd_o
);
    import swp_pkg::*;

    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] flag_q;
    pred_t              rd_q;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        logic hit;
        assign hit = set_v_i && (set_idx_i == IDX_W'(i));
        always_ff @(posedge clk) begin
            if (rst)
                flag_q[i] <= 1'b0;
            else if (hit)
                flag_q[i] <= 1'b1;
            else if (clr_i)
                flag_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q.valid    <= rd_v_i;
            rd_q.wait_bit <= rd_v_i && flag_q[rd_idx_i];
        end
    end

    assign rd_o = rd_q;

    // R3
    set_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        set_v_i |=> flag_q[$past(set_idx_i)]);

    // R6
    clear_wipes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_v_i) |=> (flag_q == '0));

    // R7
    set_over_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && set_v_i) |=> ($countones(flag_q) == 1));

    // R4
    lookup_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_v_i |=> rd_o.valid);

    // R4
    lookup_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_v_i |=> !rd_o.valid);

endmodule

// File: rtl/swp_issue_gate.sv
module swp_issue_gate #(
    parameter int OLD_W = swp_pkg::DEF_OLD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             iss_valid_i,
    input  logic             iss_wait_i,
    input  logic [OLD_W-1:0] older_i,
    output logic             grant_o,
    output logic             hold_o
);
    import swp_pkg::*;

    gate_e dec;

    always_comb begin
        dec     = gate_decide(iss_valid_i, iss_wait_i, older_i == '0);
        grant_o = (dec == GATE_PASS);
        hold_o  = (dec == GATE_HOLD);
    end

    // R8
    plain_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid_i && !iss_wait_i) |-> grant_o);

    // R9
    hold_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(grant_o && hold_o));

endmodule

// File: rtl/store_wait_predictor.sv
module store_wait_predictor #(
    parameter int PC_W         = swp_pkg::DEF_PC_W,
    parameter int IDX_W        = swp_pkg::DEF_IDX_W,
    parameter int IDX_LSB      = swp_pkg::DEF_IDX_LSB,
    parameter int CLEAR_PERIOD = swp_pkg::DEF_CLEAR_PERIOD,
    parameter int OLD_W        = swp_pkg::DEF_OLD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_valid,
    input  logic [PC_W-1:0]  fetch_pc,
    input  logic             viol_valid,
    input  logic [PC_W-1:0]  viol_pc,
    output logic             lookup_valid,
    output logic             lookup_wait,
    input  logic             iss_valid,
    input  logic             iss_wait,
    input  logic [OLD_W-1:0] older_stores,
    output logic             iss_grant,
    output logic             iss_hold
);
    import swp_pkg::*;

    localparam int IDX_HI = IDX_LSB + IDX_W;

    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] set_idx;
    logic             clr;
    pred_t            pred;
    logic             unused_pc_bits;

    assign rd_idx  = fetch_pc[IDX_LSB +: IDX_W];
    assign set_idx = viol_pc[IDX_LSB +: IDX_W];

    // Address bits outside the index slice play no part in the lookup
    if (IDX_LSB > 0 && IDX_HI < PC_W) begin : g_unused_both
        assign unused_pc_bits = ^{fetch_pc[IDX_LSB-1:0], fetch_pc[PC_W-1:IDX_HI],
                                  viol_pc[IDX_LSB-1:0], viol_pc[PC_W-1:IDX_HI]};
    end else if (IDX_LSB > 0) begin : g_unused_low
        assign unused_pc_bits = ^{fetch_pc[IDX_LSB-1:0], viol_pc[IDX_LSB-1:0]};
    end else if (IDX_HI < PC_W) begin : g_unused_high
        assign unused_pc_bits = ^{fetch_pc[PC_W-1:IDX_HI], viol_pc[PC_W-1:IDX_HI]};
    end else begin : g_unused_none
        assign unused_pc_bits = 1'b0;
    end

    swp_clear_timer #(
        .CLEAR_PERIOD(CLEAR_PERIOD)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr_o (clr)
    );

    swp_table #(
        .IDX_W(IDX_W)
    ) u_table (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (clr),
        .set_v_i   (viol_valid),
        .set_idx_i (set_idx),
        .rd_v_i    (fetch_valid),
        .rd_idx_i  (rd_idx),
        .rd_o      (pred)
    );

    swp_issue_gate #(
        .OLD_W(OLD_W)
    ) u_gate (
        .clk         (clk),
        .rst         (rst),
        .iss_valid_i (iss_valid),
        .iss_wait_i  (iss_wait),
        .older_i     (older_stores),
        .grant_o     (iss_grant),
        .hold_o      (iss_hold)
    );

    assign lookup_valid = pred.valid;
    assign lookup_wait  = pred.wait_bit;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !lookup_valid);

endmodule

// File: tb/store_wait_predictor_tb.sv
module store_wait_predictor_tb;
    localparam int PC_W   = 32;
    localparam int IDX_W  = 10;
    localparam int PERIOD = 256;
    localparam int OLD_W  = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             fetch_valid = 1'b0;
    logic [PC_W-1:0]  fetch_pc = '0;
    logic             viol_valid = 1'b0;
    logic [PC_W-1:0]  viol_pc = '0;
    logic             lookup_valid;
    logic             lookup_wait;
    logic             iss_valid = 1'b0;
    logic             iss_wait = 1'b0;
    logic [OLD_W-1:0] older_stores = '0;
    logic             iss_grant;
    logic             iss_hold;

    always #5 clk = ~clk;

    store_wait_predictor #(
        .PC_W(PC_W), .IDX_W(IDX_W), .IDX_LSB(2),
        .CLEAR_PERIOD(PERIOD), .OLD_W(OLD_W)
    ) u_dut (
        .clk(clk), .rst(rst),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .viol_valid(viol_valid), .viol_pc(viol_pc),
        .lookup_valid(lookup_valid), .lookup_wait(lookup_wait),
        .iss_valid(iss_valid), .iss_wait(iss_wait), .older_stores(older_stores),
        .iss_grant(iss_grant), .iss_hold(iss_hold)
    );

    typedef struct {
        logic  exp;
        string tag;
    } item_t;

    item_t                 sb[$];
    string                 cur_tag = "R4";
    int                    checks = 0;
    int                    errors = 0;
    int                    cyc = 0;
    logic [(1<<IDX_W)-1:0] mtbl = '0;

    function automatic int idx_of(logic [PC_W-1:0] pc);
        return int'(pc[11:2]);
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    // Model of the flag array, written from the requirements (R3, R5, R6, R7)
    always @(posedge clk) begin
        if (rst) begin
            mtbl = '0;
            cyc  = 0;
        end else begin
            if (fetch_valid) begin
                item_t it;
                it.exp = mtbl[idx_of(fetch_pc)];
                it.tag = cur_tag;
                sb.push_back(it);
            end
            if (cyc == PERIOD-1) mtbl = '0;
            if (viol_valid) mtbl[idx_of(viol_pc)] = 1'b1;
            cyc = (cyc == PERIOD-1) ? 0 : cyc + 1;
        end
    end

    // Monitor: each result is due one edge after its fetch (R4)
    always @(negedge clk) begin
        if (!rst) begin
            if (lookup_valid) begin
                if (sb.size() == 0) begin
                    chk("R4 unexpected result", 1'b1, 1'b0);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    chk(it.tag, lookup_wait, it.exp);
                end
            end else if (sb.size() != 0) begin
                item_t it;
                it = sb.pop_front();
                chk("R4 missing result", 1'b0, 1'b1);
            end
        end
    end

    task automatic drive(logic fv, logic [PC_W-1:0] fpc, logic vv, logic [PC_W-1:0] vpc);
        fetch_valid = fv;
        fetch_pc    = fpc;
        viol_valid  = vv;
        viol_pc     = vpc;
        @(negedge clk);
        fetch_valid = 1'b0;
        viol_valid  = 1'b0;
    endtask

    task automatic fetch(string tag, logic [PC_W-1:0] pc);
        cur_tag = tag;
        drive(1'b1, pc, 1'b0, '0);
    endtask

    task automatic violate(logic [PC_W-1:0] pc);
        drive(1'b0, '0, 1'b1, pc);
    endtask

    task automatic gate(string tag, logic v, logic w, int old, logic eg, logic eh);
        iss_valid    = v;
        iss_wait     = w;
        older_stores = OLD_W'(old);
        #1;
        chk({tag, " grant"}, iss_grant, eg);
        chk({tag, " hold"},  iss_hold,  eh);
        @(negedge clk);
    endtask

    task automatic wait_clear_edge();
        while (cyc != PERIOD-1) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", lookup_valid, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after reset", lookup_valid, 1'b0);

        // R1: all flags clear after reset
        fetch("R1", 32'h0000_0000);
        fetch("R1", 32'h1000_0040);
        fetch("R1", 32'h0000_0FFC);
        @(negedge clk);

        // R3: a violation raises the flag
        violate(32'h1000_0040);
        fetch("R3", 32'h1000_0040);

        // R2: aliasing through bits outside [11:2]
        fetch("R2", 32'h1000_0043);
        fetch("R2", 32'h7FFF_F040);
        fetch("R2", 32'h1000_0044);
        fetch("R2", 32'h1000_0840);

        // R5: same-edge set and fetch return the old value
        drive(1'b1, 32'h0000_0200, 1'b1, 32'h0000_0200);
        fetch("R5", 32'h0000_0200);

        // R4: back-to-back fetches, then idle cycles
        fetch("R4", 32'h0000_0200);
        fetch("R4", 32'h0000_0204);
        repeat (3) @(negedge clk);

        // R6 and R7: violation on the wipe edge wins for its entry only
        violate(32'h0000_0300);
        wait_clear_edge();
        violate(32'h0000_0400);
        fetch("R7", 32'h0000_0400);
        fetch("R6", 32'h0000_0300);
        fetch("R6", 32'h1000_0040);
        fetch("R6", 32'h0000_0200);

        // R6: a fetch on the wipe edge sees the pre-wipe flag
        violate(32'h0000_0500);
        wait_clear_edge();
        fetch("R6", 32'h0000_0500);
        fetch("R6", 32'h0000_0500);
        fetch("R7", 32'h0000_0400);

        // R8 and R9: issue gate
        gate("R8", 1'b1, 1'b0, 5, 1'b1, 1'b0);
        gate("R8", 1'b1, 1'b0, 0, 1'b1, 1'b0);
        gate("R9", 1'b1, 1'b1, 3, 1'b0, 1'b1);
        gate("R9", 1'b1, 1'b1, 1, 1'b0, 1'b1);
        gate("R9", 1'b1, 1'b1, 0, 1'b1, 1'b0);
        gate("R9", 1'b0, 1'b1, 0, 1'b0, 1'b0);
        gate("R9", 1'b0, 1'b0, 4, 1'b0, 1'b0);
        iss_valid = 1'b0;

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule